// File: doc/BRIEF.md
# Load Hit Forecaster

This block guesses whether the next integer load will find its data in the data cache. The guess sets how early the scheduler wakes the load's consumers: a hit guess schedules them at the short load-to-use latency, and a miss guess schedules them at the long one. A single saturating counter is shared by every load, with no table indexed by address. Each resolved load that hits raises the counter by one. Each resolved load that misses lowers it by two, so a short run of misses quickly turns the guess to miss.

The scheduler raises a predict strobe when it needs a guess. In the next cycle the block presents the guess bit and the latency that goes with it, and it holds both until the next strobe. When the cache returns an outcome, the resolve strobe and the hit flag train the counter. The cache, the replay logic and floating-point loads are outside this block.

Top module: `load_hit_guess`

## Requirements
- R1: After reset the counter holds its maximum value (15 for a 4-bit counter), the guess output is 1 (hit) and the latency output is 3.
- R2: A resolve with the hit flag at 1 raises the counter by 1, and the counter stays at 15 when it is already 15.
- R3: A resolve with the hit flag at 0 lowers the counter by 2 and clamps it at 0, so a counter of 1 or 0 becomes 0.
- R4: The guess is the counter's most significant bit: a counter of 8 or more gives guess 1 (hit), and 7 or less gives guess 0 (miss).
- R5: The latency output is 3 when the guess output is 1 and 5 when the guess output is 0.
- R6: Guess and latency outputs change only in the cycle after a predict strobe, and hold their values otherwise, even while resolves change the counter.
- R7: When predict and resolve come in the same cycle, the guess uses the counter value from before that resolve's update.
- R8: The counter does not change in a cycle without a resolve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| predict_i | input | 1 | Request a guess for the next load |
| resolve_i | input | 1 | A load's cache outcome is known this cycle |
| resolve_hit_i | input | 1 | Outcome with resolve_i: 1 hit, 0 miss |
| guess_hit_o | output | 1 | Last guess: 1 hit, 0 miss |
| use_lat_o | output | LAT_W (4) | Scheduled load-to-use latency in cycles |

## Verification
Streams of misses are used to walk the counter down across the guess threshold. Up to seven misses in a row tell correct clamping at 0 apart from a wrap to 15: exactly seven hits must then leave the guess at miss. Runs of hits at the top show whether the counter saturates or wraps, because a fixed count of misses afterwards must end just below the threshold. Resolves without a predict strobe check that the outputs hold their values. A predict and a resolve in the same cycle, placed right at the threshold, tell the pre-update counter value apart from the post-update value.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  // Saturating step of the shared counter: up by UP on a hit, down by DN on
  // a miss, clamped to [0, top].
  function automatic int unsigned sat_step(input int unsigned cur,
                                           input int unsigned top,
                                           input bit          hit,
                                           input int unsigned up,
                                           input int unsigned dn);
    int unsigned res;
    if (hit) res = (cur + up > top) ? top : cur + up;
    else     res = (cur < dn) ? 0 : cur - dn;
    return res;
  endfunction

  // Load-to-use latency that goes with a guess.
  function automatic int unsigned pick_latency(input bit guess_hit,
                                               input int unsigned lat_hit,
                                               input int unsigned lat_miss);
    return guess_hit ? lat_hit : lat_miss;
  endfunction

endpackage

// File: rtl/lhp_sat_counter.sv
module lhp_sat_counter #(
  parameter int unsigned W  = 4,
  parameter int unsigned UP = 1,
  parameter int unsigned DN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_i,
  input  logic         hit_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o
);
  import lhp_pkg::*;

  localparam int unsigned TOP = (1 << W) - 1;

  logic [W-1:0] cnt_q;

  always_comb begin
    if (upd_i) nxt_o = W'(sat_step(int'(cnt_q), TOP, hit_i, UP, DN));
    else       nxt_o = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= W'(TOP);
    else        cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lhp_latency_map.sv
module lhp_latency_map #(
  parameter int unsigned LAT_W    = 4,
  parameter int unsigned LAT_HIT  = 3,
  parameter int unsigned LAT_MISS = 5
) (
  input  logic             guess_i,
  output logic [LAT_W-1:0] lat_o
);
  import lhp_pkg::*;

  always_comb lat_o = LAT_W'(pick_latency(guess_i, LAT_HIT, LAT_MISS));
endmodule

// File: rtl/lhp_snapshot.sv
module lhp_snapshot #(
  parameter int unsigned LAT_W     = 4,
  parameter int unsigned RST_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             guess_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             guess_o,
  output logic [LAT_W-1:0] lat_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      guess_o <= 1'b1;
      lat_o   <= LAT_W'(RST_LAT);
    end else if (take_i) begin
      guess_o <= guess_i;
      lat_o   <= lat_i;
    end
  end
endmodule

// File: rtl/load_hit_guess.sv
module load_hit_guess #(
  parameter int unsigned CTR_W    = 4,
  parameter int unsigned HIT_INC  = 1,
  parameter int unsigned MISS_DEC = 2,
  parameter int unsigned LAT_W    = 4,
  parameter int unsigned LAT_HIT  = 3,
  parameter int unsigned LAT_MISS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             predict_i,
  input  logic             resolve_i,
  input  logic             resolve_hit_i,
  output logic             guess_hit_o,
  output logic [LAT_W-1:0] use_lat_o
);
  localparam int unsigned MSB = CTR_W - 1;

  // Named internal events, exposed for the checker.
  logic [CTR_W-1:0] ctr_q;
  logic [CTR_W-1:0] ctr_d;
  logic             live_guess;
  logic [LAT_W-1:0] live_lat;
  logic             train_hit;
  logic             train_miss;

  assign train_hit  = resolve_i &  resolve_hit_i;
  assign train_miss = resolve_i & ~resolve_hit_i;

  lhp_sat_counter #(.W(CTR_W), .UP(HIT_INC), .DN(MISS_DEC)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .upd_i (resolve_i),
    .hit_i (resolve_hit_i),
    .cnt_o (ctr_q),
    .nxt_o (ctr_d)
  );

  // The guess reads the registered value, so a same-cycle resolve is not seen.
  assign live_guess = ctr_q[MSB];

  lhp_latency_map #(.LAT_W(LAT_W), .LAT_HIT(LAT_HIT), .LAT_MISS(LAT_MISS)) u_lat (
    .guess_i (live_guess),
    .lat_o   (live_lat)
  );

  lhp_snapshot #(.LAT_W(LAT_W), .RST_LAT(LAT_HIT)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (predict_i),
    .guess_i (live_guess),
    .lat_i   (live_lat),
    .guess_o (guess_hit_o),
    .lat_o   (use_lat_o)
  );
endmodule

// File: rtl/lhp_checker.sv
module lhp_checker #(
  parameter int unsigned CTR_W    = 4,
  parameter int unsigned LAT_W    = 4,
  parameter int unsigned LAT_HIT  = 3,
  parameter int unsigned LAT_MISS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             predict_i,
  input logic             resolve_i,
  input logic             resolve_hit_i,
  input logic             guess_hit_o,
  input logic [LAT_W-1:0] use_lat_o,
  input logic [CTR_W-1:0] ctr_q
);
  localparam logic [CTR_W-1:0] TOP = {CTR_W{1'b1}};
  localparam logic [CTR_W-1:0] TWO = CTR_W'(2);

  AST_RESET_FULL: assert property (@(posedge clk) $rose(rst_n) |-> (ctr_q == TOP && guess_hit_o)); // R1

  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && resolve_hit_i && ctr_q != TOP) |=> ctr_q == CTR_W'($past(ctr_q) + CTR_W'(1))); // R2

  AST_HIT_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && resolve_hit_i && ctr_q == TOP) |=> ctr_q == TOP); // R2

  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && !resolve_hit_i && ctr_q >= TWO) |=> ctr_q == CTR_W'($past(ctr_q) - TWO)); // R3

  AST_MISS_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_i && !resolve_hit_i && ctr_q < TWO) |=> ctr_q == '0); // R3

  AST_GUESS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    predict_i |=> guess_hit_o == $past(ctr_q[CTR_W-1])); // R4 R7

  AST_LAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    use_lat_o == (guess_hit_o ? LAT_W'(LAT_HIT) : LAT_W'(LAT_MISS))); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !predict_i |=> ($stable(guess_hit_o) && $stable(use_lat_o))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_i |=> $stable(ctr_q)); // R8
endmodule

bind load_hit_guess lhp_checker #(
  .CTR_W(CTR_W), .LAT_W(LAT_W), .LAT_HIT(LAT_HIT), .LAT_MISS(LAT_MISS)
) u_lhp_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .predict_i     (predict_i),
  .resolve_i     (resolve_i),
  .resolve_hit_i (resolve_hit_i),
  .guess_hit_o   (guess_hit_o),
  .use_lat_o     (use_lat_o),
  .ctr_q         (ctr_q)
);

// File: tb/test_load_hit_guess.sv
module test_load_hit_guess;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       predict_i = 1'b0;
  logic       resolve_i = 1'b0;
  logic       resolve_hit_i = 1'b0;
  logic       guess_hit_o;
  logic [3:0] use_lat_o;

  int errors = 0;
  int checks = 0;
  int mdl = 15;   // bench's own view of the counter

  always #10 clk = ~clk;   // 50 MHz

  load_hit_guess i_load_hit_guess (
    .clk(clk), .rst_n(rst_n), .predict_i(predict_i), .resolve_i(resolve_i),
    .resolve_hit_i(resolve_hit_i), .guess_hit_o(guess_hit_o), .use_lat_o(use_lat_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mdl_next(input int c, input bit hit);
    if (hit) return (c == 15) ? 15 : c + 1;
    return (c <= 1) ? 0 : c - 2;
  endfunction

  task automatic resolve_n(input bit hit, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      resolve_i = 1'b1; resolve_hit_i = hit;
      @(negedge clk);
      resolve_i = 1'b0;
      mdl = mdl_next(mdl, hit);
    end
  endtask

  // Predict and compare both outputs against the counter before this edge.
  task automatic predict_check(input string req);
    bit eg;
    @(negedge clk);
    predict_i = 1'b1;
    eg = (mdl >= 8);
    @(negedge clk);
    predict_i = 1'b0;
    check({req, " guess"}, int'(guess_hit_o), int'(eg));
    check({req, " latency R5"}, int'(use_lat_o), eg ? 3 : 5);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset guess", int'(guess_hit_o), 1);
    check("R1 reset latency", int'(use_lat_o), 3);
    predict_check("R1 first predict");
  endtask

  task automatic t_top_saturate;
    resolve_n(1'b1, 3);      // stays 15 (R2)
    resolve_n(1'b0, 4);      // 15 -> 7 only if no wrap (R3)
    predict_check("R2 ceiling then R4 below threshold");
    resolve_n(1'b1, 1);      // 7 -> 8
    predict_check("R2 step R4 at threshold");
  endtask

  task automatic t_floor;
    resolve_n(1'b0, 3);      // 8 -> 2 -> ... -> 2
    resolve_n(1'b0, 1);      // 2 -> 0
    resolve_n(1'b1, 1);      // 1
    resolve_n(1'b0, 1);      // 1 -> 0 clamp (R3)
    resolve_n(1'b0, 2);      // stays 0
    resolve_n(1'b1, 7);      // 7
    predict_check("R3 floor clamp, 7 hits");
    resolve_n(1'b1, 1);      // 8
    predict_check("R3 floor clamp, 8 hits");
  endtask

  task automatic t_hold;
    // counter at 8, outputs show hit
    resolve_n(1'b0, 1);      // 6, no predict
    check("R6 hold guess", int'(guess_hit_o), 1);
    check("R6 hold latency", int'(use_lat_o), 3);
    repeat (3) @(negedge clk);
    check("R6 hold guess idle", int'(guess_hit_o), 1);
    predict_check("R6 refresh");
  endtask

  task automatic t_same_cycle;
    bit eg;
    resolve_n(1'b1, 1);      // 7
    @(negedge clk);
    predict_i = 1'b1; resolve_i = 1'b1; resolve_hit_i = 1'b1;
    eg = (mdl >= 8);         // pre-update view: 7 -> miss
    @(negedge clk);
    predict_i = 1'b0; resolve_i = 1'b0;
    mdl = mdl_next(mdl, 1'b1);
    check("R7 same-cycle guess", int'(guess_hit_o), int'(eg));
    check("R7 same-cycle latency", int'(use_lat_o), eg ? 3 : 5);
    predict_check("R7 after update");
  endtask

  task automatic t_idle;
    // counter at 8: idle cycles must not move it
    repeat (10) @(negedge clk);
    predict_check("R8 idle keeps counter");
    resolve_n(1'b0, 1);      // 6
    repeat (10) @(negedge clk);
    predict_check("R8 idle keeps low counter");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_top_saturate();
    t_floor();
    t_hold();
    t_same_cycle();
    t_idle();
    repeat (2) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule